// File: doc/BRIEF.md
# Timer Channel Status Flags

This block holds the event status of one channel of a 16-bit timer. It keeps three sticky flags: one for counter wrap, one for a compare match or capture on general register B, and one for a compare match or capture on general register A. The counter logic sets each flag with a single-cycle pulse. Each flag, ANDed with its own enable bit, drives a level interrupt request.

Software reads the flags through an 8-bit register port. The top five bits always read as 1. A flag cannot be cleared by a blind write. A read must first return the flag as 1, which arms that bit. A later write with a 0 in that bit then clears it. Any write disarms all three bits.

A built-in wrap detector watches the counter value, its step strobe and its direction. It raises the wrap event when the counter steps up from all-ones or steps down from zero. A standby input returns the block to its reset state.

Top module: `tmr_stat_flags`

## Requirements
- R1: After reset, `rdata` reads 0xF8 (flags in bits 2..0 all 0) and `irq` is 0.
- R2: Bits 7..3 of `rdata` always read as 1, whatever was written.
- R3: A one-cycle pulse on `evt_cmp_a` sets bit 0, and a pulse on `evt_cmp_b` sets bit 1. Each is visible from the next cycle and stays set until cleared.
- R4: When `cnt_step` is 1, `cnt_down` is 0 and `cnt_val` is 0xFFFF, the wrap flag (bit 2) is set in the next cycle. Stepping up from any other value does not set it.
- R5: When `cnt_step` is 1, `cnt_down` is 1 and `cnt_val` is 0x0000, bit 2 is set. Stepping down from other values does not set it, and neither does a value of 0xFFFF without a step.
- R6: A write of 0 to a flag bit does not clear that flag unless a read has returned the flag as 1 since the last write.
- R7: After a read returns a flag as 1, a write with 0 in that bit clears it. Flags written as 1 are kept. The write disarms every bit.
- R8: Writing 1 to a flag bit never sets the flag and never clears it.
- R9: If a set event and a qualifying clearing write hit the same flag in the same cycle, the flag ends up 1.
- R10: `irq[i]` equals flag bit i AND `ien[i]` at all times.
- R11: Asserting `stby` for one cycle returns `rdata` to 0xF8 and clears the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby | input | 1 | Synchronous return to reset state |
| rd_en | input | 1 | Register read strobe; arms flags that read as 1 |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data; bits 2..0 are the flag clear mask (0 = clear) |
| rdata | output | 8 | Readback: {5'b11111, wrap, cmp_b, cmp_a} |
| evt_cmp_a | input | 1 | Compare/capture event pulse for register A |
| evt_cmp_b | input | 1 | Compare/capture event pulse for register B |
| cnt_step | input | 1 | Counter advances this cycle |
| cnt_down | input | 1 | Counting direction, 1 = down |
| cnt_val | input | CNT_W | Current counter value |
| ien | input | 3 | Interrupt enables, same bit order as the flags |
| irq | output | 3 | Interrupt requests, same bit order as the flags |

## Verification
On every cycle the assertions check four things: the reserved bits read as ones, each interrupt output equals its flag masked by its enable, a flag never rises without its event, and each event or counter wrap shows in the flag one cycle later. The read-then-write clear sequence depends on history that no simple property captures. This covers blind writes, disarming by an intervening write, partial clear masks, and a set that collides with a clear. Only the bench scenarios show these, by reading the register back after each step.

// File: rtl/tmr_stat_flags.sv
module tmr_stat_flags #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stby,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic             evt_cmp_a,
  input  logic             evt_cmp_b,
  input  logic             cnt_step,
  input  logic             cnt_down,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [2:0]       ien,
  output logic [2:0]       irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  logic [2:0] flag_q, armed_q, set_v, clr_v;
  logic       wrap;

  assign wrap  = cnt_step & (cnt_down ? (cnt_val == CNT_MIN) : (cnt_val == CNT_MAX));
  assign set_v = {wrap, evt_cmp_b, evt_cmp_a};
  assign clr_v = wr_en ? (armed_q & ~wdata[2:0]) : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      armed_q <= '0;
    end else if (stby) begin
      flag_q  <= '0;
      armed_q <= '0;
    end else begin
      flag_q  <= set_v | (flag_q & ~clr_v);
      armed_q <= wr_en ? 3'b000 : (armed_q | (rd_en ? flag_q : 3'b000));
    end
  end

  assign rdata = {5'b11111, flag_q};
  assign irq   = flag_q & ien;
endmodule

// File: rtl/tmr_stat_flags_chk.sv
module tmr_stat_flags_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stby,
  input logic             evt_cmp_a,
  input logic             evt_cmp_b,
  input logic             cnt_step,
  input logic             cnt_down,
  input logic [CNT_W-1:0] cnt_val,
  input logic [2:0]       ien,
  input logic [2:0]       irq,
  input logic [7:0]       rdata
);
  // R2
  reserved_ones_chk: assert property (@(posedge clk) disable iff (!rst_n) rdata[7:3] == 5'b11111);
  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n) irq == (rdata[2:0] & ien));
  // R3
  cmp_a_set_chk: assert property (@(posedge clk) disable iff (!rst_n || stby) evt_cmp_a |=> rdata[0]);
  // R3
  cmp_b_set_chk: assert property (@(posedge clk) disable iff (!rst_n || stby) evt_cmp_b |=> rdata[1]);
  // R4
  wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n || stby)
    (cnt_step && !cnt_down && cnt_val == {CNT_W{1'b1}}) |=> rdata[2]);
  // R5
  wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n || stby)
    (cnt_step && cnt_down && cnt_val == {CNT_W{1'b0}}) |=> rdata[2]);
  // R8
  no_soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata[0]) |-> $past(evt_cmp_a));
  // R11
  stby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) stby |=> rdata == 8'hF8);
endmodule

bind tmr_stat_flags tmr_stat_flags_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stby(stby), .evt_cmp_a(evt_cmp_a), .evt_cmp_b(evt_cmp_b),
  .cnt_step(cnt_step), .cnt_down(cnt_down), .cnt_val(cnt_val), .ien(ien), .irq(irq),
  .rdata(rdata)
);

// File: tb/tmr_stat_flags_bench.sv
module tmr_stat_flags_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stby = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        evt_cmp_a = 1'b0, evt_cmp_b = 1'b0, cnt_step = 1'b0, cnt_down = 1'b0;
  logic [15:0] cnt_val = 16'h0000;
  logic [2:0]  ien = 3'b000;
  logic [2:0]  irq;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #5 clk = ~clk;

  tmr_stat_flags #(.CNT_W(16)) u_tmr_stat_flags (
    .clk(clk), .rst_n(rst_n), .stby(stby), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .evt_cmp_a(evt_cmp_a), .evt_cmp_b(evt_cmp_b), .cnt_step(cnt_step),
    .cnt_down(cnt_down), .cnt_val(cnt_val), .ien(ien), .irq(irq)
  );

  // monitor: pops expected readback for every read cycle
  always @(negedge clk) begin
    if (rd_en && exp_q.size() > 0) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s rdata got=%h exp=%h", t, rdata, e);
      end
    end
  end

  task automatic drive(input bit rd, input bit wr, input logic [7:0] wd, input bit ea, input bit eb,
                       input bit st, input bit dn, input logic [15:0] cv);
    @(posedge clk); #2;
    rd_en = rd; wr_en = wr; wdata = wd; evt_cmp_a = ea; evt_cmp_b = eb;
    cnt_step = st; cnt_down = dn; cnt_val = cv;
  endtask

  task automatic idle();
    drive(0, 0, 8'h00, 0, 0, 0, 0, 16'h1234);
  endtask

  task automatic rd(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    drive(1, 0, 8'h00, 0, 0, 0, 0, 16'h1234);
  endtask

  task automatic wr(input logic [7:0] d);
    drive(0, 1, d, 0, 0, 0, 0, 16'h1234);
  endtask

  task automatic chk_irq(input logic [2:0] e, input string t);
    @(negedge clk);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s irq got=%b exp=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    chk_irq(3'b000, "R1");
    rd(8'hF8, "R1");
    wr(8'h00); rd(8'hF8, "R2");
    // R3 events, R6 blind write
    drive(0, 0, 8'h00, 1, 0, 0, 0, 16'h1234);
    drive(0, 0, 8'h00, 0, 1, 0, 0, 16'h1234);
    wr(8'h00); rd(8'hFB, "R6 R3");
    // armed both; partial clear of A only
    wr(8'hFE); rd(8'hFA, "R7 partial");
    // armed B; writing 1 keeps it
    wr(8'hFF); rd(8'hFA, "R8 keep");
    wr(8'h00); rd(8'hF8, "R7 clear");
    wr(8'h07); rd(8'hF8, "R8 no set");
    // wrap detection
    drive(0, 0, 8'h00, 0, 0, 1, 0, 16'hFFFE); rd(8'hF8, "R4 no wrap");
    drive(0, 0, 8'h00, 0, 0, 1, 0, 16'hFFFF); rd(8'hFC, "R4 wrap up");
    wr(8'h00); rd(8'hF8, "R7 wrap clr");
    drive(0, 0, 8'h00, 0, 0, 1, 0, 16'h0000);
    drive(0, 0, 8'h00, 0, 0, 1, 1, 16'hFFFF);
    drive(0, 0, 8'h00, 0, 0, 0, 1, 16'h0000);
    rd(8'hF8, "R5 no wrap");
    drive(0, 0, 8'h00, 0, 0, 1, 1, 16'h0000); rd(8'hFC, "R5 wrap down");
    // R9 collision: armed bit 2, clear write with wrap same cycle
    drive(0, 1, 8'h00, 0, 0, 1, 1, 16'h0000); rd(8'hFC, "R9");
    // R10
    idle(); ien = 3'b100; chk_irq(3'b100, "R10 en");
    ien = 3'b000; chk_irq(3'b000, "R10 off");
    drive(0, 0, 8'h00, 1, 0, 0, 0, 16'h1234); idle();
    ien = 3'b111; chk_irq(3'b101, "R10 mix");
    // R11
    rd(8'hFD, "R11 pre");
    @(posedge clk); #2 rd_en = 1'b0; stby = 1'b1;
    @(posedge clk); #2 stby = 1'b0;
    chk_irq(3'b000, "R11 irq");
    rd(8'hF8, "R11");
    wr(8'h00);
    drive(0, 0, 8'h00, 1, 0, 0, 0, 16'h1234);
    wr(8'h00); rd(8'hF9, "R11 disarmed");
    idle(); idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule